// File: doc/BRIEF.md
# Clocked Serial Command/Data Receiver

This block takes a write-only serial stream from a host and turns it into 8-bit bytes, each marked as either a command or display data. The host drives a serial clock, a serial data line, a data/command select line and a chip select made of two signals: an active-low select and an active-high select. The block brings all of these into the system clock domain through a two-stage synchronizer and finds the rising edges of the serial clock. On each rising edge it shifts in one data bit, most significant bit first.

No separate frame signal marks the byte boundaries. Framing comes only from a bit counter. The counter is cleared whenever the chip select goes inactive, and it wraps after every eighth bit, so bytes can follow each other without a deselect. The data/command line is read only on the eighth rising edge of each byte. Each finished byte appears on a parallel output with a valid strobe that lasts one system clock. Downstream register or RAM logic uses these outputs. There is no read path.

Top module: `serial_cmd_rx`

## Requirements
- R1: Bits are shifted in on rising serial-clock edges, most significant bit first. The first bit received ends up in byte_out[7] and the eighth in byte_out[0].
- R2: `byte_valid` rises once, for exactly one system cycle, after the eighth rising serial-clock edge of a byte. After fewer than eight edges no strobe is produced.
- R3: `byte_is_data` takes the level of the data/command line at the eighth rising edge: 1 marks display data and 0 marks a command. The line's level at the other seven edges has no effect.
- R4: While the chip is deselected, the bit counter and the shift register are held clear. A partial byte that is cut off by a deselect is discarded, and the next selection starts a fresh byte.
- R5: The receiver is selected only while `cs_n_in` is 0 and `cs_in` is 1. If either signal is at its other level, serial-clock edges produce no byte.
- R6: After the eighth bit the counter wraps to zero, so consecutive bytes are received without a deselect between them.
- R7: While `rst_n` is low on a clock edge, `byte_out` goes to 0, `byte_valid` to 0 and `byte_is_data` to 0.
- R8: `byte_out` and `byte_is_data` hold their values between strobes and change only in the cycle where `byte_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sclk_in | input | 1 | Serial clock from the host, asynchronous to clk |
| sdata_in | input | 1 | Serial data, MSB first |
| dc_sel_in | input | 1 | Data/command select: 1 = display data, 0 = command |
| cs_n_in | input | 1 | Chip select, active low |
| cs_in | input | 1 | Chip select, active high |
| byte_out | output | 8 | Last assembled byte |
| byte_valid | output | 1 | One-cycle strobe for a new byte |
| byte_is_data | output | 1 | Flag for the last byte: 1 = display data, 0 = command |

## Verification
The assertions check four things on every cycle. The strobe lasts a single cycle. The outputs hold between strobes. The counter is clear while deselected. Every byte is preceded by a selected serial-clock edge and takes its flag from the synchronized select line. Only the bench scenarios can show the rest: the bit order, the exact edge on which a byte completes, discarding a partial byte after a deselect, the treatment of each chip-select combination, and back-to-back framing. Each of these depends on a specific sequence of host bits.

// File: rtl/ser_rx_pkg.sv
// Package: shared sizes for the serial command/data receiver.
// Assumes: byte width is a power of two of at least 2.
package ser_rx_pkg;
    parameter int unsigned BYTE_W      = 8;
    parameter int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/ser_sync_chain.sv
// Module: ser_sync_chain
// Brings W asynchronous single-bit inputs into the clk domain through
// a chain of STAGES flip-flops per bit.
// Assumes: each input bit is treated on its own; STAGES >= 2.
module ser_sync_chain #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Pass the value along one more stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/ser_rise_detect.sv
// Module: ser_rise_detect
// Turns a synchronized serial clock into a one-cycle pulse on each
// low-to-high transition.
// Assumes: level_in is already in the clk domain.
module ser_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise_out
);
    logic level_d;

    // Remember the previous level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level_in;
    end

    assign rise_out = level_in & ~level_d;

    // A rise can never be seen on two cycles in a row (supports R2).
    assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_out |=> !rise_out);
endmodule

// File: rtl/ser_byte_framer.sv
// Module: ser_byte_framer
// Shifts bits in MSB first on each sample enable and counts them. On
// every BYTE_W-th bit it emits the byte, its data/command flag and a
// one-cycle strobe. Counter and shift register are held clear while
// the chip is deselected.
// Assumes: sample_en is a single-cycle pulse; bit_in/dc_in are aligned to it.
module ser_byte_framer #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              sample_en,
    input  logic              bit_in,
    input  logic              dc_in,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_valid,
    output logic              byte_is_data
);
    localparam int unsigned CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shift_q;
    logic [BYTE_W-1:0] shift_next;

    assign shift_next = {shift_q[BYTE_W-2:0], bit_in};

    // Count and shift bits; clear both while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            bit_cnt <= '0;
            shift_q <= '0;
        end else if (sample_en) begin
            shift_q <= shift_next;
            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        end
    end

    // Publish a finished byte with its flag and a single-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_out     <= '0;
            byte_is_data <= 1'b0;
            byte_valid   <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (active && sample_en && bit_cnt == LAST_BIT) begin
                byte_out     <= shift_next;
                byte_is_data <= dc_in;
                byte_valid   <= 1'b1;
            end
        end
    end

    assert_valid_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);
    assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |-> ($stable(byte_out) && $stable(byte_is_data)));
    assert_count_clear_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (bit_cnt == '0 && shift_q == '0));
endmodule

// File: rtl/serial_cmd_rx.sv
// Module: serial_cmd_rx (top)
// Write-only serial receiver: synchronizes the host lines, detects the
// rising edges of the serial clock and frames 8-bit command/data bytes.
// Assumes: each serial clock phase lasts at least two clk periods.
module serial_cmd_rx
    import ser_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic              sdata_in,
    input  logic              dc_sel_in,
    input  logic              cs_n_in,
    input  logic              cs_in,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_valid,
    output logic              byte_is_data
);
    localparam int unsigned NSYNC = 5;

    logic [NSYNC-1:0] raw_lines;
    logic [NSYNC-1:0] sync_lines;
    logic sclk_s, sdata_s, dc_s, cs_n_s, cs_s;
    logic sel_active;
    logic sclk_rise;

    assign raw_lines = {cs_in, cs_n_in, dc_sel_in, sdata_in, sclk_in};
    assign {cs_s, cs_n_s, dc_s, sdata_s, sclk_s} = sync_lines;
    assign sel_active = ~cs_n_s & cs_s;

    ser_sync_chain #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_lines),
        .sync_out (sync_lines)
    );

    ser_rise_detect u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (sclk_s),
        .rise_out (sclk_rise)
    );

    ser_byte_framer #(.BYTE_W(BYTE_W)) u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       (sel_active),
        .sample_en    (sclk_rise),
        .bit_in       (sdata_s),
        .dc_in        (dc_s),
        .byte_out     (byte_out),
        .byte_valid   (byte_valid),
        .byte_is_data (byte_is_data)
    );

    assert_byte_needs_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> $past(!cs_n_s && cs_s && sclk_rise));
    assert_flag_from_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (byte_is_data == $past(dc_s)));
endmodule

// File: tb/serial_cmd_rx_tb.sv
module serial_cmd_rx_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_in = 1'b0, sdata_in = 1'b0, dc_sel_in = 1'b0;
    logic cs_n_in = 1'b1, cs_in = 1'b0;
    logic [7:0] byte_out;
    logic byte_valid, byte_is_data;

    int checks = 0;
    int fails = 0;
    int vcount = 0;
    logic [7:0] last_byte = 8'h00;
    logic last_flag = 1'b0;
    logic prev_valid = 1'b0;
    int double_pulse = 0;

    always #4 clk = ~clk;  // 125 MHz

    serial_cmd_rx u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdata_in(sdata_in),
        .dc_sel_in(dc_sel_in), .cs_n_in(cs_n_in), .cs_in(cs_in),
        .byte_out(byte_out), .byte_valid(byte_valid), .byte_is_data(byte_is_data)
    );

    // Monitor: record strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) begin
                vcount++;
                last_byte = byte_out;
                last_flag = byte_is_data;
                if (prev_valid) double_pulse++;
            end
            prev_valid = byte_valid;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial bit: low phase with data set, then rising edge, high phase.
    task automatic send_bit(input bit b, input bit dc);
        @(negedge clk);
        sclk_in = 1'b0; sdata_in = b; dc_sel_in = dc;
        wait_clks(4);
        sclk_in = 1'b1;
        wait_clks(5);
    endtask

    // dc_last applies at the eighth edge, dc_other at the first seven.
    task automatic send_byte(input logic [7:0] v, input bit dc_last, input bit dc_other);
        for (int i = 7; i >= 0; i--) send_bit(v[i], (i == 0) ? dc_last : dc_other);
    endtask

    task automatic select(input bit on);
        @(negedge clk);
        cs_n_in = ~on; cs_in = on;
        wait_clks(4);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        wait_clks(3);
        check(byte_out == 8'h00, "R7 byte_out", byte_out, 0);
        check(byte_valid == 1'b0, "R7 byte_valid", byte_valid, 0);
        check(byte_is_data == 1'b0, "R7 byte_is_data", byte_is_data, 0);
        rst_n = 1'b1;
        wait_clks(2);
    endtask

    task automatic t_basic;
        int v0;
        select(1);
        v0 = vcount;
        for (int i = 7; i >= 1; i--) send_bit(1'b1, 1'b1);
        check(vcount == v0, "R2 no strobe after seven edges", vcount - v0, 0);
        send_bit(1'b0, 1'b1);
        check(vcount == v0 + 1, "R2 strobe after eighth edge", vcount - v0, 1);
        check(last_byte == 8'hFE, "R1 MSB first", last_byte, 8'hFE);
        check(last_flag == 1'b1, "R3 data flag", last_flag, 1);
        check(byte_out == 8'hFE, "R8 output held", byte_out, 8'hFE);
        select(0);
    endtask

    task automatic t_command_flag;
        select(1);
        send_byte(8'hA5, 1'b0, 1'b1);
        check(last_byte == 8'hA5, "R1 pattern A5", last_byte, 8'hA5);
        check(last_flag == 1'b0, "R3 command flag, other edges ignored", last_flag, 0);
        send_byte(8'h3C, 1'b1, 1'b0);
        check(last_flag == 1'b1, "R3 data flag, other edges ignored", last_flag, 1);
        select(0);
    endtask

    task automatic t_back_to_back;
        int v0;
        select(1);
        v0 = vcount;
        send_byte(8'h81, 1'b0, 1'b0);
        check(last_byte == 8'h81, "R6 first byte", last_byte, 8'h81);
        send_byte(8'h7E, 1'b1, 1'b1);
        check(last_byte == 8'h7E, "R6 second byte", last_byte, 8'h7E);
        send_byte(8'h00, 1'b0, 1'b0);
        check(vcount == v0 + 3, "R6 three strobes", vcount - v0, 3);
        check(last_byte == 8'h00, "R6 third byte", last_byte, 0);
        select(0);
    endtask

    task automatic t_abort;
        select(1);
        for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
        select(0);
        select(1);
        send_byte(8'h12, 1'b1, 1'b0);
        check(last_byte == 8'h12, "R4 partial discarded", last_byte, 8'h12);
        select(0);
    endtask

    task automatic t_deselect_combos;
        int v0;
        v0 = vcount;
        @(negedge clk); cs_n_in = 1'b1; cs_in = 1'b1; wait_clks(4);
        send_byte(8'h55, 1'b1, 1'b1);
        check(vcount == v0, "R5 cs_n high ignored", vcount - v0, 0);
        @(negedge clk); cs_n_in = 1'b0; cs_in = 1'b0; wait_clks(4);
        send_byte(8'h66, 1'b1, 1'b1);
        check(vcount == v0, "R5 cs low ignored", vcount - v0, 0);
        check(byte_out == 8'h12, "R8 output kept while deselected", byte_out, 8'h12);
        select(1);
        send_byte(8'hC3, 1'b0, 1'b1);
        check(last_byte == 8'hC3, "R4 fresh after idle edges", last_byte, 8'hC3);
        select(0);
    endtask

    initial begin
        wait_clks(2);
        t_reset();
        t_basic();
        t_command_flag();
        t_back_to_back();
        t_abort();
        t_deselect_combos();
        check(double_pulse == 0, "R2 strobe one cycle", double_pulse, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule